// File: doc/BRIEF.md
# Programmable Dual Square-Wave Clock Generator

This block makes two independent, slow square waves from a fast system clock. For each channel, a single 32-bit configuration word sets the length of the high phase and the length of the low phase. Both lengths are counted in ticks of one of four binary-weighted timebases, and each channel picks its own timebase. A shared prescaler turns the system clock into tick enables. Its division ratio comes from a clock-frequency parameter, so a short tick can be used in simulation.

Each channel is a two-state machine with the states `PH_HIGH` and `PH_LOW`, plus a 7-bit down counter. The counter moves only on the channel's selected tick. There are two transitions:

- `PH_HIGH -> PH_LOW` happens on a selected tick when the counter is zero. The counter reloads with the low count.
- `PH_LOW -> PH_HIGH` happens on a selected tick when the counter is zero. The counter reloads with the high count.

On any other selected tick, the state holds and the counter decrements. With no selected tick, both state and counter hold. The output is high while the state is `PH_HIGH`.

Top module: `dual_phase_clkgen`

## Requirements
- R1: During and straight after reset, the configuration word reads 32'hFFFF_FFFF and both outputs are high.
- R2: A write stores all 32 bits, and the new value reads back on the next cycle. The field layout is as follows. Channel 1 timebase is bits [31:30], channel 1 high count is [29:23] and channel 1 low count is [22:16]. Channel 0 timebase is bits [15:14], channel 0 high count is [13:7] and channel 0 low count is [6:0].
- R3: The base tick period is SYS_CLK_HZ/4000 system cycles. The timebase code sets the channel's tick period: 2'b00 is 1 base tick, 2'b01 is 8 base ticks, 2'b10 is 64 base ticks and 2'b11 is 512 base ticks.
- R4: A high count H gives a high phase of exactly (H+1) channel ticks.
- R5: A low count L gives a low phase of exactly (L+1) channel ticks. A count of 0 gives one tick.
- R6: After reset, each channel starts in `PH_HIGH` with its counter loaded from the reset high count (127). If timebase 2'b00 is written on the first cycle after reset, the first falling edge comes exactly 128 base ticks after reset is released.
- R7: A write does not shorten or lengthen the phase in progress. New counts are used from the next reload. The timebase select applies from the next tick.
- R8: The two channels run independently, each with its own counts and its own timebase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration value to write |
| cfg_rdata | output | 32 | Current configuration word |
| clk_out | output | 2 | Generated square waves, bit 0 = channel 0 |

## Verification
The hardest case to reach is a write that lands partway through a phase. The bench must show that the running phase still ends on its old count, while the following phases use the new counts. To get there, the bench first locks onto a rising edge of channel 0, counts a known number of cycles into the high phase, and writes shorter counts. It then checks that the high phase still spans the full old length and that the next low phase is short. The R6 start-up phase is reached by writing the fastest timebase right after reset, so the 127-count reset load drains in a bounded number of cycles.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int CNT_W   = 7;
    localparam int NUM_TB  = 4;
    localparam int SEL_W   = 2;
    localparam int NUM_CH  = 2;

    typedef enum logic [SEL_W-1:0] {
        TB_X1   = 2'b00,
        TB_X8   = 2'b01,
        TB_X64  = 2'b10,
        TB_X512 = 2'b11
    } timebase_e;

    typedef struct packed {
        timebase_e          base;
        logic [CNT_W-1:0]   hi_cnt;
        logic [CNT_W-1:0]   lo_cnt;
    } chan_cfg_t;

    localparam int CFG_W = NUM_CH * $bits(chan_cfg_t);

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/clkgen_prescaler.sv
module clkgen_prescaler #(
    parameter int BASE_DIV  = 12500,
    parameter int STEP_LOG2 = 3,
    parameter int NUM_BASES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [NUM_BASES-1:0] tick_o
);

    localparam int PRE_W  = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam int MULT_W = STEP_LOG2 * (NUM_BASES - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [MULT_W-1:0] mult_q;
    logic              base_pulse;

    assign base_pulse = (pre_q == PRE_W'(BASE_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            mult_q <= '0;
        end else begin
            if (base_pulse) begin
                pre_q  <= '0;
                mult_q <= mult_q + MULT_W'(1);
            end else begin
                pre_q  <= pre_q + PRE_W'(1);
            end
        end
    end

    assign tick_o[0] = base_pulse;

    for (genvar k = 1; k < NUM_BASES; k++) begin : g_tick
        assign tick_o[k] = base_pulse & (&mult_q[STEP_LOG2*k-1:0]);
    end

    // Period checker: consecutive pulses of each tick must be exactly one period apart.
    for (genvar k = 0; k < NUM_BASES; k++) begin : g_per_chk
        localparam int PERIOD = BASE_DIV * (1 << (STEP_LOG2 * k));
        logic [31:0] gap_q;
        logic        seen_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap_q  <= '0;
                seen_q <= 1'b0;
            end else if (tick_o[k]) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else begin
                gap_q  <= gap_q + 32'd1;
            end
        end

        p_tick_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_o[k] && seen_q) |-> (gap_q == 32'(PERIOD - 1)));
    end

endmodule

// File: rtl/clkgen_cfg_reg.sv
module clkgen_cfg_reg
    import clkgen_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [CFG_W-1:0]       wdata_i,
    output logic [CFG_W-1:0]       rdata_o,
    output chan_cfg_t [NUM_CH-1:0] cfg_o
);

    chan_cfg_t [NUM_CH-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '1;
        end else if (we_i) begin
            cfg_q <= wdata_i;
        end
    end

    assign cfg_o   = cfg_q;
    assign rdata_o = cfg_q;

    p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(rdata_o));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (rdata_o == $past(wdata_i)));

endmodule

// File: rtl/clkgen_channel.sv
module clkgen_channel
    import clkgen_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_CNT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_TB-1:0] tick_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [CNT_W-1:0]  hi_i,
    input  logic [CNT_W-1:0]  lo_i,
    output logic              out_o
);

    phase_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             tick_en;

    assign tick_en = tick_i[sel_i];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_HIGH;
            cnt_q   <= RST_CNT;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick_en) begin
            unique case (state_q)
                PH_HIGH: begin
                    if (cnt_q == '0) begin
                        state_d = PH_LOW;
                        cnt_d   = lo_i;
                    end else begin
                        cnt_d   = cnt_q - CNT_W'(1);
                    end
                end
                PH_LOW: begin
                    if (cnt_q == '0) begin
                        state_d = PH_HIGH;
                        cnt_d   = hi_i;
                    end else begin
                        cnt_d   = cnt_q - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        out_o = (state_q == PH_HIGH);
    end

    p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(out_o) && $stable(cnt_q)));

    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)) && $stable(out_o)));

    p_fall_loads_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_q == '0 && out_o) |=> (!out_o && cnt_q == $past(lo_i)));

    p_rise_loads_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_q == '0 && !out_o) |=> (out_o && cnt_q == $past(hi_i)));

endmodule

// File: rtl/dual_phase_clkgen.sv
module dual_phase_clkgen
    import clkgen_pkg::*;
#(
    parameter int SYS_CLK_HZ = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [1:0]  clk_out
);

    localparam int BASE_HZ   = 4000;
    localparam int BASE_DIV  = (SYS_CLK_HZ / BASE_HZ > 0) ? SYS_CLK_HZ / BASE_HZ : 1;
    localparam int STEP_LOG2 = 3;

    logic [NUM_TB-1:0]      ticks;
    chan_cfg_t [NUM_CH-1:0] cfg;

    clkgen_prescaler #(
        .BASE_DIV  (BASE_DIV),
        .STEP_LOG2 (STEP_LOG2),
        .NUM_BASES (NUM_TB)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (ticks)
    );

    clkgen_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .cfg_o   (cfg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        clkgen_channel #(
            .RST_CNT ('1)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (ticks),
            .sel_i  (cfg[g].base),
            .hi_i   (cfg[g].hi_cnt),
            .lo_i   (cfg[g].lo_cnt),
            .out_o  (clk_out[g])
        );
    end

    p_reset_high_r1: assert property (@(posedge clk)
        !rst_n |=> (clk_out == 2'b11 && cfg_rdata == 32'hFFFF_FFFF));

endmodule

// File: tb/tb_dual_phase_clkgen.sv
module tb_dual_phase_clkgen;

    localparam int SYS_HZ = 16000;
    localparam int D      = SYS_HZ / 4000;
    localparam int LIM    = 60000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  clk_out;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    dual_phase_clkgen #(.SYS_CLK_HZ(SYS_HZ)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .clk_out   (clk_out)
    );

    function automatic int tick_cyc(int sel);
        return D * (1 << (3 * sel));
    endfunction

    function automatic logic [15:0] field(int sel, int hi, int lo);
        return {2'(sel), 7'(hi), 7'(lo)};
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R2", "readback", cfg_rdata, v);
    endtask

    // Skip to a fresh rising edge, then count one full high and one full low phase.
    task automatic meas(int ch, output int hi, output int lo);
        int n = 0;
        while (clk_out[ch] !== 1'b0 && n < LIM) begin @(negedge clk); n++; end
        while (clk_out[ch] !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
        hi = 1;
        forever begin
            @(negedge clk);
            if (clk_out[ch] === 1'b1 && hi < LIM) hi++; else break;
        end
        lo = 1;
        forever begin
            @(negedge clk);
            if (clk_out[ch] === 1'b0 && lo < LIM) lo++; else break;
        end
    endtask

    task automatic run_cfg(int s0, int h0, int l0, int s1, int h1, int l1, string req);
        int hi, lo;
        write_cfg({field(s1, h1, l1), field(s0, h0, l0)});
        meas(0, hi, lo);
        check(req, $sformatf("ch0 high s%0d h%0d", s0, h0), hi, (h0 + 1) * tick_cyc(s0));
        check(req, $sformatf("ch0 low s%0d l%0d", s0, l0), lo, (l0 + 1) * tick_cyc(s0));
        meas(1, hi, lo);
        check(req, $sformatf("ch1 high s%0d h%0d", s1, h1), hi, (h1 + 1) * tick_cyc(s1));
        check(req, $sformatf("ch1 low s%0d l%0d", s1, l1), lo, (l1 + 1) * tick_cyc(s1));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int hi, lo;
        repeat (3) @(negedge clk);
        check("R1", "rdata in reset", cfg_rdata, 32'hFFFF_FFFF);
        check("R1", "outputs in reset", clk_out, 2'b11);

        // R6: release reset, select fastest timebase at once, keep counts at 127
        rst_n = 1'b1;
        check("R1", "outputs after release", clk_out, 2'b11);
        cfg_we = 1'b1;
        cfg_wdata = {field(0, 127, 127), field(0, 127, 127)};
        n = 0;
        @(negedge clk);
        n++;
        cfg_we = 1'b0;
        check("R2", "first write readback", cfg_rdata, 32'h3FFF_3FFF);
        while (clk_out[0] === 1'b1 && n < LIM) begin @(negedge clk); n++; end
        check("R6", "cycles to first fall ch0", n, 128 * D);
        check("R6", "ch1 falls together", clk_out[1], 1'b0);

        // R4/R5: near-exhaustive count sweep on the fastest timebase
        for (int h = 0; h < 8; h++) begin
            for (int l = 0; l < 8; l++) begin
                run_cfg(0, h, l, 0, l, 7 - h, "R4/R5");
            end
        end

        // R3: each timebase code
        for (int s = 0; s < 4; s++) begin
            run_cfg(s, 1, 2, s, 2, 0, "R3");
        end

        // R5/R4 extremes of the 7-bit count
        run_cfg(0, 127, 0, 1, 0, 127, "R5");

        // R8: channels on different timebases and counts
        run_cfg(2, 0, 1, 0, 3, 5, "R8");

        // R7: write in the middle of a high phase
        write_cfg({field(0, 1, 1), field(0, 20, 20)});
        meas(0, hi, lo);
        check("R7", "settle high", hi, 21 * D);
        hi = 1;
        repeat (9) begin @(negedge clk); if (clk_out[0] === 1'b1) hi++; end
        cfg_we = 1'b1;
        cfg_wdata = {field(0, 1, 1), field(0, 2, 2)};
        @(negedge clk);
        cfg_we = 1'b0;
        if (clk_out[0] === 1'b1) hi++;
        forever begin
            @(negedge clk);
            if (clk_out[0] === 1'b1 && hi < LIM) hi++; else break;
        end
        lo = 1;
        forever begin
            @(negedge clk);
            if (clk_out[0] === 1'b0 && lo < LIM) lo++; else break;
        end
        check("R7", "phase in progress keeps old length", hi, 21 * D);
        check("R7", "next low uses new count", lo, 3 * D);
        meas(0, hi, lo);
        check("R7", "later high uses new count", hi, 3 * D);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule